// File: doc/BRIEF.md
# PHY Interrupt and Power-Down Pin Controller

This block sits beside the management register file of a 10/100 Ethernet PHY. It owns two management registers: a control register that chooses the role of one shared active-low pin and gates interrupts globally, and a combined status/mask register. In that register the lower byte holds one enable per interrupt source and the upper byte holds one pending flag per source. Internal sources raise single-cycle event pulses, for example on a link-state change or an energy-detect change. Each pulse latches a pending flag. While the pin is set up as an output, the block pulls the pin low for as long as any enabled flag is pending. A read of the status/mask register clears all pending flags.

After reset the pin is an input. When it is low, it requests power-down, in the same way as the power-down bit of the basic mode control register. That bit arrives on its own input. Once software turns the pin into an interrupt output, the pin level no longer affects power-down. A device held in power-down by the pin can therefore be brought out of it with one register write. The pin itself is modelled as an open-drain pull-low enable plus a sampled pad level. Serial management framing and power gating sit outside the block.

Top module: `phy_irq_pin_ctrl`

## Requirements
- R1: After reset the control register, the mask byte and all pending flags read 0. The pin is released, and the pin acts as the power-down input.
- R2: The control register is at address 0x0A. Bit 0 selects the pin role (1 = interrupt output) and bit 1 is the global interrupt enable. Bits 15:2 read as 0 whatever was written.
- R3: The status/mask register is at address 0x0B. A write stores bits 7:0 as the mask, and writes to bits 15:8 are ignored.
- R4: An event pulse on source n sets pending bit 8+n of the status/mask register on the next clock edge, even when mask bit n is 0.
- R5: A read of address 0x0B returns the pending flags in bits 15:8 and the mask in bits 7:0. It clears every pending flag at that clock edge. A read of any other address clears nothing.
- R6: An event that arrives in the same cycle as a clearing read is not reported in that read, and it stays pending afterwards.
- R7: The pin is pulled low only when control bit 0 is 1, control bit 1 is 1, and some source has both its pending flag and its mask bit set. The pull-low follows the pending register with no further clock delay.
- R8: After a clearing read with no new event, the pin is released right after that clock edge.
- R9: With control bit 0 at 0, a low pad level asserts power_down_req after SYNC_STAGES (default 2) clock edges, and a high level removes it after the same delay.
- R10: The power-down bit of the basic mode control register asserts power_down_req in the same cycle, whatever the pin role.
- R11: While control bit 0 is 1, the pad level has no effect on power_down_req. Setting the bit drops a pin-driven power-down right after the write edge.
- R12: Mask value 0x0060 enables source 5 (link change) and source 6 (energy-detect change). An event on either source then pulls the pin low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Management clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid while reg_rd is high |
| evt_pulse | input | 8 | One-cycle event pulses, one bit per source |
| bmcr_pd | input | 1 | Power-down bit of the basic mode control register |
| pin_in | input | 1 | Sampled level of the shared pad |
| pin_drive_low | output | 1 | Open-drain enable: 1 pulls the pad low |
| power_down_req | output | 1 | Power-down request to the power controller |

## Verification
If a pending flag is lost or cleared wrongly, the port shows it at once: the pin stays released, or it keeps pulling low, right after the edge of the event or the read. The next read of the status/mask register shows the wrong upper byte. A wrong mask or control bit shows up as a pin that ignores an enabled source, or as one that fires while gated. The fault is visible one cycle after the write. Faults in the pin-role and synchronizer path show up in the power-down request. A missed or extra stage shifts its rise by a cycle. A role gate that leaks lets the pad hold power-down after the role has changed.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;

    localparam int SRC_N   = 8;
    localparam int DATA_W  = 2 * SRC_N;
    localparam int REG_AW  = 5;

    localparam logic [REG_AW-1:0] CTL_ADDR  = 5'h0A;
    localparam logic [REG_AW-1:0] STAT_ADDR = 5'h0B;

    typedef struct packed {
        logic irq_en;
        logic pin_out_en;
    } irq_ctl_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTL  = 2'd1,
        SEL_STAT = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic             wr;
        logic             rd;
        reg_sel_e         sel;
        logic [SRC_N-1:0] wdata;
    } reg_req_t;

    function automatic reg_sel_e decode_addr(input logic [REG_AW-1:0] a);
        if (a == CTL_ADDR)       return SEL_CTL;
        else if (a == STAT_ADDR) return SEL_STAT;
        else                     return SEL_NONE;
    endfunction

    function automatic logic [DATA_W-1:0] pack_stat(input logic [SRC_N-1:0] pend,
                                                    input logic [SRC_N-1:0] mask);
        return {pend, mask};
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctl(input irq_ctl_t c);
        return {{(DATA_W-2){1'b0}}, c};
    endfunction

endpackage

// File: rtl/phy_irq_regs.sv
module phy_irq_regs
    import phy_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  reg_req_t          req,
    input  logic [SRC_N-1:0]  pend,
    output irq_ctl_t          ctl,
    output logic [SRC_N-1:0]  mask,
    output logic [DATA_W-1:0] rdata,
    output logic              clr_all
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl  <= '0;
            mask <= '0;
        end else if (req.wr) begin
            case (req.sel)
                SEL_CTL:  ctl  <= irq_ctl_t'(req.wdata[1:0]);
                SEL_STAT: mask <= req.wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (req.rd) begin
            case (req.sel)
                SEL_CTL:  rdata = pack_ctl(ctl);
                SEL_STAT: rdata = pack_stat(pend, mask);
                default:  rdata = '0;
            endcase
        end
    end

    assign clr_all = req.rd && (req.sel == SEL_STAT);

    AST_MASK_LOADS: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == SEL_STAT) |=> (mask == $past(req.wdata))); // R3
    AST_CTL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(req.wr && req.sel == SEL_CTL) |=> $stable(ctl)); // R2
    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(req.wr && req.sel == SEL_STAT) |=> $stable(mask)); // R3

endmodule

// File: rtl/phy_irq_pending.sv
module phy_irq_pending
    import phy_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] evt,
    input  logic             clr,
    output logic [SRC_N-1:0] pend
);

    for (genvar i = 0; i < SRC_N; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst)         pend[i] <= 1'b0;
            else if (evt[i]) pend[i] <= 1'b1;
            else if (clr)    pend[i] <= 1'b0;
        end
    end

    AST_EVT_KEPT: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((pend & $past(evt)) == $past(evt))); // R6
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (clr && !(|evt)) |=> (pend == '0)); // R5
    AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (rst)
        (!(|evt)) |=> ((pend & ~$past(pend)) == '0)); // R4

endmodule

// File: rtl/phy_pd_pin.sv
module phy_pd_pin #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_in,
    input  logic pin_out_en,
    input  logic irq_assert,
    input  logic bmcr_pd,
    output logic pin_drive_low,
    output logic pd_req
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sync_q[g] <= 1'b1;
                else     sync_q[g] <= pin_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sync_q[g] <= 1'b1;
                else     sync_q[g] <= sync_q[g-1];
            end
        end
    end

    assign pin_drive_low = pin_out_en & irq_assert;
    assign pd_req        = bmcr_pd | (~pin_out_en & ~sync_q[LAST]);

    AST_BMCR_FORCES_PD: assert property (@(posedge clk) disable iff (rst)
        bmcr_pd |-> pd_req); // R10
    AST_OUT_ROLE_NO_PD: assert property (@(posedge clk) disable iff (rst)
        (pin_out_en && !bmcr_pd) |-> !pd_req); // R11
    AST_IN_ROLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !pin_out_en |-> !pin_drive_low); // R7

endmodule

// File: rtl/phy_irq_pin_ctrl.sv
module phy_irq_pin_ctrl
    import phy_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [SRC_N-1:0]  evt_pulse,
    input  logic              bmcr_pd,
    input  logic              pin_in,
    output logic              pin_drive_low,
    output logic              power_down_req
);

    reg_req_t         req;
    irq_ctl_t         ctl;
    logic [SRC_N-1:0] mask;
    logic [SRC_N-1:0] pend;
    logic             clr_all;
    logic             irq_assert;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:SRC_N];

    always_comb begin
        req.wr    = reg_wr;
        req.rd    = reg_rd;
        req.sel   = decode_addr(reg_addr);
        req.wdata = reg_wdata[SRC_N-1:0];
    end

    phy_irq_regs i_regs (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .pend    (pend),
        .ctl     (ctl),
        .mask    (mask),
        .rdata   (reg_rdata),
        .clr_all (clr_all)
    );

    phy_irq_pending i_pend (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt_pulse),
        .clr  (clr_all),
        .pend (pend)
    );

    assign irq_assert = ctl.irq_en & (|(pend & mask));

    phy_pd_pin #(.SYNC_STAGES(SYNC_STAGES)) i_pin (
        .clk           (clk),
        .rst           (rst),
        .pin_in        (pin_in),
        .pin_out_en    (ctl.pin_out_en),
        .irq_assert    (irq_assert),
        .bmcr_pd       (bmcr_pd),
        .pin_drive_low (pin_drive_low),
        .pd_req        (power_down_req)
    );

    AST_DRIVE_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        pin_drive_low |-> (ctl.irq_en && ctl.pin_out_en && (|(pend & mask)))); // R7
    AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (clr_all && !(|evt_pulse)) |=> !pin_drive_low); // R8

endmodule

// File: tb/test_phy_irq_pin_ctrl.sv
module test_phy_irq_pin_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  evt_pulse = '0;
    logic        bmcr_pd = 1'b0;
    logic        ext_low = 1'b0;
    logic        pin_in;
    logic        pin_drive_low;
    logic        power_down_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } rd_item_t;

    rd_item_t sb_q[$];

    localparam logic [4:0] A_CTL  = 5'h0A;
    localparam logic [4:0] A_STAT = 5'h0B;

    always #10 clk = ~clk;

    assign pin_in = !(ext_low || pin_drive_low);

    phy_irq_pin_ctrl i_phy_irq_pin_ctrl (
        .clk            (clk),
        .rst            (rst),
        .reg_wr         (reg_wr),
        .reg_rd         (reg_rd),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .evt_pulse      (evt_pulse),
        .bmcr_pd        (bmcr_pd),
        .pin_in         (pin_in),
        .pin_drive_low  (pin_drive_low),
        .power_down_req (power_down_req)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag,
                      input logic [7:0] evt_same);
        rd_item_t it;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        reg_rd = 1'b1; reg_addr = a; evt_pulse = evt_same;
        tick();
        reg_rd = 1'b0; evt_pulse = '0;
    endtask

    task automatic pulse(input logic [7:0] e);
        evt_pulse = e;
        tick();
        evt_pulse = '0;
    endtask

    // scoreboard monitor: pops one expected read per read cycle
    initial begin
        forever begin
            @(negedge clk);
            if (reg_rd) begin
                if (sb_q.size() == 0) begin
                    n_tests++; n_fail++;
                    $display("FAIL scoreboard: read %h with no expected item", reg_rdata);
                end else begin
                    rd_item_t it;
                    it = sb_q.pop_front();
                    chk(reg_rdata, it.exp, it.tag);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk({15'b0, pin_drive_low}, 16'h0, "R1 pin released");
        chk({15'b0, power_down_req}, 16'h0, "R1 no power-down");
        rd(A_CTL,  16'h0000, "R1 ctl reset", 8'h00);
        rd(A_STAT, 16'h0000, "R1 stat reset", 8'h00);
        // R2 control register bits
        wr(A_CTL, 16'hFFFF);
        rd(A_CTL, 16'h0003, "R2 reserved bits zero", 8'h00);
        wr(A_CTL, 16'h0000);
        rd(A_CTL, 16'h0000, "R2 ctl cleared", 8'h00);
        // R3 mask byte only
        wr(A_STAT, 16'hAB60);
        rd(A_STAT, 16'h0060, "R3 upper byte write ignored", 8'h00);
        // R4 unmasked source still latches
        pulse(8'h01);
        chk({15'b0, pin_drive_low}, 16'h0, "R4 no drive while input role");
        rd(A_STAT, 16'h0160, "R4 unmasked pending", 8'h00);
        rd(A_STAT, 16'h0060, "R5 cleared by read", 8'h00);
        // R12 link and energy-detect sources
        wr(A_CTL, 16'h0003);
        pulse(8'h20);
        chk({15'b0, pin_drive_low}, 16'h1, "R12 link event drives pin");
        chk({15'b0, power_down_req}, 16'h0, "R11 low pin ignored in output role");
        rd(A_STAT, 16'h2060, "R5 link pending", 8'h00);
        chk({15'b0, pin_drive_low}, 16'h0, "R8 released after read");
        pulse(8'h40);
        chk({15'b0, pin_drive_low}, 16'h1, "R12 energy event drives pin");
        rd(A_STAT, 16'h4060, "R5 energy pending", 8'h00);
        chk({15'b0, pin_drive_low}, 16'h0, "R8 released after read 2");
        // R7 masked-off source
        pulse(8'h08);
        chk({15'b0, pin_drive_low}, 16'h0, "R7 masked source no drive");
        rd(A_STAT, 16'h0860, "R4 masked source pending", 8'h00);
        // R7 global enable gating
        wr(A_CTL, 16'h0001);
        pulse(8'h20);
        chk({15'b0, pin_drive_low}, 16'h0, "R7 global enable off");
        wr(A_CTL, 16'h0003);
        chk({15'b0, pin_drive_low}, 16'h1, "R7 enable exposes pending");
        rd(A_STAT, 16'h2060, "R5 clear after enable", 8'h00);
        chk({15'b0, pin_drive_low}, 16'h0, "R8 released after read 3");
        // R7 pin role gating
        wr(A_CTL, 16'h0002);
        pulse(8'h20);
        chk({15'b0, pin_drive_low}, 16'h0, "R7 input role no drive");
        chk({15'b0, power_down_req}, 16'h0, "R9 high pad no power-down");
        rd(A_STAT, 16'h2060, "R5 clear in input role", 8'h00);
        // R6 event during clearing read
        wr(A_CTL, 16'h0003);
        pulse(8'h20);
        rd(A_STAT, 16'h2060, "R6 read excludes new event", 8'h40);
        chk({15'b0, pin_drive_low}, 16'h1, "R6 new event keeps pin low");
        rd(A_STAT, 16'h4060, "R6 new event kept", 8'h00);
        chk({15'b0, pin_drive_low}, 16'h0, "R8 released after read 4");
        // R5 other address does not clear
        pulse(8'h20);
        rd(A_CTL, 16'h0003, "R5 ctl read", 8'h00);
        chk({15'b0, pin_drive_low}, 16'h1, "R5 ctl read keeps pending");
        rd(A_STAT, 16'h2060, "R5 still pending", 8'h00);
        // R9 synchronized power-down input
        wr(A_CTL, 16'h0000);
        ext_low = 1'b1;
        tick();
        chk({15'b0, power_down_req}, 16'h0, "R9 one edge not yet");
        tick();
        chk({15'b0, power_down_req}, 16'h1, "R9 asserted after two edges");
        // R11 switch role drops pin power-down
        wr(A_CTL, 16'h0001);
        chk({15'b0, power_down_req}, 16'h0, "R11 output role exits power-down");
        wr(A_CTL, 16'h0000);
        chk({15'b0, power_down_req}, 16'h1, "R9 input role again");
        ext_low = 1'b0;
        tick();
        chk({15'b0, power_down_req}, 16'h1, "R9 release one edge");
        tick();
        chk({15'b0, power_down_req}, 16'h0, "R9 released after two edges");
        // R10 basic control power-down bit
        wr(A_CTL, 16'h0003);
        bmcr_pd = 1'b1;
        #1;
        chk({15'b0, power_down_req}, 16'h1, "R10 bmcr in output role");
        wr(A_CTL, 16'h0000);
        chk({15'b0, power_down_req}, 16'h1, "R10 bmcr in input role");
        bmcr_pd = 1'b0;
        #1;
        chk({15'b0, power_down_req}, 16'h0, "R10 bmcr removed");
        tick();
        chk(16'(sb_q.size()), 16'h0, "R5 all reads observed");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule